// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block sits beside a small 8-bit processor core. It collects single-cycle request pulses from five peripheral sources into a sticky flag register. Each flag is qualified by a per-source enable register. Both registers can be read and written over the core's byte-wide data bus. The block also holds the master interrupt enable. The core's instruction decoder sets or clears it through two strobes.

The block continuously forms the pending set, which is each flag ANDed with its enable. Any pending source raises a wake level that releases a halted core, whatever the master enable is. Dispatch starts when three things hold in the same cycle: the core reports an instruction boundary, the master enable is set, and something is pending. Dispatch then runs a fixed 20-clock sequence made of five 4-clock machine cycles. The sequence:

- drops the master enable;
- clears the flag of the single highest-priority source;
- pushes the interrupted program counter to the stack, high byte first, through a byte write port;
- hands the core a new stack pointer and the handler address.

Top module: `irq_ctrl`

## Requirements
- R1: A pulse on `req_i[k]` sets flag bit k on the next clock edge, whatever enable bit k holds. Flags stay set until they are written or serviced. The source order is: bit 0 frame blank, bit 1 display status, bit 2 timer overflow, bit 3 serial done, bit 4 keypad.
- R2: A read at address 0xFF0F returns the flag register, and a read at 0xFFFF returns the enable register, each with bits 7..5 forced to 1. A read at any other address returns 0xFF.
- R3: A bus write to 0xFF0F or 0xFFFF stores data bits 4..0 into the flag or enable register. Data bits 7..5 are discarded.
- R4: If a request pulse and a bus write to the flag register land in the same cycle, the requested bit ends up set.
- R5: `wake_o` is high exactly when some bit is set in both the flag and enable registers, regardless of the master enable.
- R6: Dispatch starts on a clock edge where `insn_bound_i`, the master enable and a non-empty pending set all hold. It clears the master enable and clears only the flag bit being serviced.
- R7: The serviced source is the lowest-numbered pending bit. Its handler address is 0x0040 + 8 × bit index.
- R8: `busy_o` stays high for exactly 20 clocks from the start edge. `pc_load_o` and `sp_load_o` pulse in the 20th of those clocks.
- R9: During dispatch, `mem_we_o` pulses in clock 9 with address SP−1 and data PC[15:8], then in clock 13 with address SP−2 and data PC[7:0]. PC and SP are the values sampled at the start edge. `sp_o` returns SP−2.
- R10: `ime_set_i` sets the master enable and `ime_clr_i` clears it. A dispatch start overrides a simultaneous `ime_set_i`.
- R11: After reset, the flag register, the enable register and the master enable are all zero, and no dispatch is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 5 | Request pulses, one per source |
| bus_addr_i | input | 16 | Bus address |
| bus_we_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data (combinational) |
| ime_set_i | input | 1 | Set master enable |
| ime_clr_i | input | 1 | Clear master enable |
| ime_o | output | 1 | Master enable state |
| wake_o | output | 1 | Pending set non-empty |
| insn_bound_i | input | 1 | Core is at an instruction boundary |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| busy_o | output | 1 | Dispatch in progress |
| mem_we_o | output | 1 | Stack byte write strobe |
| mem_addr_o | output | 16 | Stack write address |
| mem_wdata_o | output | 8 | Stack write data |
| pc_load_o | output | 1 | Load `pc_o` into the program counter |
| pc_o | output | 16 | Handler address |
| sp_load_o | output | 1 | Load `sp_o` into the stack pointer |
| sp_o | output | 16 | Decremented stack pointer |

## Verification
The bench sweeps every enable value against every flag value with the master enable off. A design that gated wake on the master enable, or that leaked data bits 7..5 into storage or readback, fails this sweep. Each of the 31 non-empty pending sets is then dispatched with a distinct PC and SP. This exposes the following faults:

- a wrong priority choice or handler address;
- clearing every pending flag instead of only the serviced one;
- a push in the wrong clock, a wrong byte order or a wrong stack offset;
- a sequence that ends early or late.

Further directed cases cover a request racing a flag-register write, and a dispatch colliding with an enable-set strobe. A design that let the write or the strobe win would show a cleared flag or a master enable left set.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int unsigned NSRC       = 5;
  localparam int unsigned DW         = 8;
  localparam int unsigned AW         = 16;
  localparam int unsigned MCLK       = 4;   // clocks per machine cycle
  localparam int unsigned DMCYC      = 5;   // machine cycles per dispatch
  localparam logic [15:0] FLAG_ADDR  = 16'hFF0F;
  localparam logic [15:0] EN_ADDR    = 16'hFFFF;
  localparam logic [15:0] VEC_BASE   = 16'h0040;
  localparam int unsigned VEC_STRIDE = 8;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT,
    PH_PUSH,
    PH_JUMP
  } dsp_phase_e;
endpackage

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs #(
  parameter int unsigned NSRC      = irq_pkg::NSRC,
  parameter int unsigned DW        = irq_pkg::DW,
  parameter int unsigned AW        = irq_pkg::AW,
  parameter logic [AW-1:0] FLAG_ADDR = irq_pkg::FLAG_ADDR,
  parameter logic [AW-1:0] EN_ADDR   = irq_pkg::EN_ADDR
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic            bus_we_i,
  input  logic [NSRC-1:0] bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic [NSRC-1:0] flag_o,
  output logic [NSRC-1:0] en_o
);
  localparam int unsigned PADW = DW - NSRC;

  logic [NSRC-1:0] flag_q, flag_d, en_q, en_d;
  logic            wr_flag, wr_en;

  assign wr_flag = bus_we_i && (bus_addr_i == FLAG_ADDR);
  assign wr_en   = bus_we_i && (bus_addr_i == EN_ADDR);

  always_comb begin
    // service clear first, then requests override everything
    flag_d = ((wr_flag ? bus_wdata_i : flag_q) & ~clr_i) | req_i;
    en_d   = wr_en ? bus_wdata_i : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    if (bus_addr_i == FLAG_ADDR)    bus_rdata_o = {{PADW{1'b1}}, flag_q};
    else if (bus_addr_i == EN_ADDR) bus_rdata_o = {{PADW{1'b1}}, en_q};
    else                            bus_rdata_o = '1;
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_prio.sv
`timescale 1ns/1ps
module irq_prio #(
  parameter int unsigned NSRC = irq_pkg::NSRC,
  localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] pend_i,
  output logic            any_o,
  output logic [NSRC-1:0] grant_o,
  output logic [IDXW-1:0] idx_o
);
  logic [NSRC:0] below;

  assign below[0] = 1'b0;
  for (genvar g = 0; g < NSRC; g++) begin : g_chain
    assign grant_o[g]  = pend_i[g] & ~below[g];
    assign below[g+1]  = below[g] | pend_i[g];
  end

  assign any_o = below[NSRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant_o[i]) idx_o = idx_o | IDXW'(i);
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
`timescale 1ns/1ps
module irq_dispatch #(
  parameter int unsigned   AW         = irq_pkg::AW,
  parameter int unsigned   DW         = irq_pkg::DW,
  parameter int unsigned   IDXW       = 3,
  parameter int unsigned   MCLK       = irq_pkg::MCLK,
  parameter int unsigned   DMCYC      = irq_pkg::DMCYC,
  parameter logic [AW-1:0] VEC_BASE   = irq_pkg::VEC_BASE,
  parameter int unsigned   VEC_STRIDE = irq_pkg::VEC_STRIDE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [AW-1:0]   sp_i,
  output logic            busy_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            pc_load_o,
  output logic [AW-1:0]   pc_o,
  output logic            sp_load_o,
  output logic [AW-1:0]   sp_o
);
  import irq_pkg::*;

  localparam int unsigned TOT    = MCLK * DMCYC;
  localparam int unsigned CW     = $clog2(TOT);
  localparam int unsigned HI_AT  = 2 * MCLK;
  localparam int unsigned LO_AT  = 3 * MCLK;

  logic            busy_q;
  logic [CW-1:0]   cnt_q;
  logic [IDXW-1:0] idx_q;
  logic [AW-1:0]   pc_q, sp_q;
  dsp_phase_e      phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      pc_q   <= '0;
      sp_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        idx_q  <= idx_i;
        pc_q   <= pc_i;
        sp_q   <= sp_i;
      end
    end else if (cnt_q == CW'(TOT - 1)) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  always_comb begin
    if (!busy_q)                        phase = PH_IDLE;
    else if (cnt_q == CW'(TOT - 1))     phase = PH_JUMP;
    else if (cnt_q == CW'(HI_AT) ||
             cnt_q == CW'(LO_AT))       phase = PH_PUSH;
    else                                phase = PH_WAIT;
  end

  assign busy_o      = busy_q;
  assign mem_we_o    = (phase == PH_PUSH);
  assign mem_addr_o  = (cnt_q == CW'(HI_AT)) ? sp_q - AW'(1) : sp_q - AW'(2);
  assign mem_wdata_o = (cnt_q == CW'(HI_AT)) ? pc_q[AW-1:AW-DW] : pc_q[DW-1:0];
  assign pc_load_o   = (phase == PH_JUMP);
  assign sp_load_o   = (phase == PH_JUMP);
  assign pc_o        = VEC_BASE + (AW'(idx_q) * AW'(VEC_STRIDE));
  assign sp_o        = sp_q - AW'(2);
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl #(
  parameter int unsigned   NUM_SRC    = irq_pkg::NSRC,
  parameter int unsigned   DW         = irq_pkg::DW,
  parameter int unsigned   AW         = irq_pkg::AW,
  parameter int unsigned   MCLK       = irq_pkg::MCLK,
  parameter int unsigned   DMCYC      = irq_pkg::DMCYC,
  parameter logic [AW-1:0] FLAG_ADDR  = irq_pkg::FLAG_ADDR,
  parameter logic [AW-1:0] EN_ADDR    = irq_pkg::EN_ADDR,
  parameter logic [AW-1:0] VEC_BASE   = irq_pkg::VEC_BASE,
  parameter int unsigned   VEC_STRIDE = irq_pkg::VEC_STRIDE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic               bus_we_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  input  logic               ime_set_i,
  input  logic               ime_clr_i,
  output logic               ime_o,
  output logic               wake_o,
  input  logic               insn_bound_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [AW-1:0]      sp_i,
  output logic               busy_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  output logic               pc_load_o,
  output logic [AW-1:0]      pc_o,
  output logic               sp_load_o,
  output logic [AW-1:0]      sp_o
);
  localparam int unsigned IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] if_q, ie_q, pend, grant, clr;
  logic [IDXW-1:0]    idx;
  logic               any_pend, start, ime_q;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DW-1:NUM_SRC];

  irq_regs #(
    .NSRC(NUM_SRC), .DW(DW), .AW(AW),
    .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .clr_i       (clr),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i[NUM_SRC-1:0]),
    .bus_rdata_o (bus_rdata_o),
    .flag_o      (if_q),
    .en_o        (ie_q)
  );

  assign pend = if_q & ie_q;

  irq_prio #(.NSRC(NUM_SRC)) u_prio (
    .pend_i  (pend),
    .any_o   (any_pend),
    .grant_o (grant),
    .idx_o   (idx)
  );

  assign start = insn_bound_i && ime_q && any_pend && !busy_o;
  assign clr   = start ? grant : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ime_q <= 1'b0;
    else if (start)     ime_q <= 1'b0;
    else if (ime_set_i) ime_q <= 1'b1;
    else if (ime_clr_i) ime_q <= 1'b0;
  end

  assign ime_o  = ime_q;
  assign wake_o = any_pend;

  irq_dispatch #(
    .AW(AW), .DW(DW), .IDXW(IDXW), .MCLK(MCLK), .DMCYC(DMCYC),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_dsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .idx_i       (idx),
    .pc_i        (pc_i),
    .sp_i        (sp_i),
    .busy_o      (busy_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .pc_load_o   (pc_load_o),
    .pc_o        (pc_o),
    .sp_load_o   (sp_load_o),
    .sp_o        (sp_o)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk #(
  parameter int unsigned NSRC = irq_pkg::NSRC,
  parameter int unsigned TOT  = irq_pkg::MCLK * irq_pkg::DMCYC
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] req_i,
  input logic [NSRC-1:0] if_q,
  input logic            ime_o,
  input logic            busy_o,
  input logic            mem_we_o,
  input logic            pc_load_o,
  input logic            sp_load_o
);
  localparam int unsigned RW = $clog2(TOT) + 1;
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + RW'(1);
    else             run_cnt <= '0;
  end

  // R1
  req_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> ((if_q & $past(req_i)) == $past(req_i)));

  // R6
  ime_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !ime_o);

  // R9
  push_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o && !pc_load_o);

  // R8
  jump_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> (run_cnt == RW'(TOT - 1)) && sp_load_o);

  // R8
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_cnt < RW'(TOT)));
endmodule

bind irq_ctrl irq_ctrl_chk #(
  .NSRC(NUM_SRC),
  .TOT (MCLK * DMCYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .if_q      (if_q),
  .ime_o     (ime_o),
  .busy_o    (busy_o),
  .mem_we_o  (mem_we_o),
  .pc_load_o (pc_load_o),
  .sp_load_o (sp_load_o)
);

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;
  localparam logic [15:0] A_FLAG = 16'hFF0F;
  localparam logic [15:0] A_EN   = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  req = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ime_set = 1'b0, ime_clr = 1'b0, ime;
  logic        wake, bound = 1'b0;
  logic [15:0] pc = '0, sp = '0;
  logic        busy, mem_we, pc_load, sp_load;
  logic [15:0] mem_addr, pc_out, sp_out;
  logic [7:0]  mem_wdata;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .bus_addr_i(bus_addr), .bus_we_i(bus_we), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .ime_set_i(ime_set), .ime_clr_i(ime_clr),
    .ime_o(ime), .wake_o(wake), .insn_bound_i(bound), .pc_i(pc), .sp_i(sp),
    .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .pc_load_o(pc_load), .pc_o(pc_out),
    .sp_load_o(sp_load), .sp_o(sp_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic dispatch(input logic [4:0] p, input logic [15:0] pc0,
                          input logic [15:0] sp0, input bit race_set);
    logic [7:0] r;
    int idx;
    idx = 0;
    for (int i = 4; i >= 0; i--) if (p[i]) idx = i;
    bus_wr(A_EN, 8'h1F);
    bus_wr(A_FLAG, {3'b000, p});
    ime_set = 1'b1; step(); ime_set = 1'b0;
    chk(ime == 1'b1, "R10 ime set", ime, 1);
    pc = pc0; sp = sp0; bound = 1'b1; ime_set = race_set;
    step();
    bound = 1'b0; ime_set = 1'b0; pc = 16'hDEAD; sp = 16'hBEEF;
    chk(busy == 1'b1, "R8 busy at start", busy, 1);
    chk(ime == 1'b0, race_set ? "R10 start beats set" : "R6 ime cleared", ime, 0);
    rd(A_FLAG, r);
    chk(r == (8'hE0 | {3'b000, p & ~(5'(1) << idx)}), "R6 only serviced flag cleared",
        r, 8'hE0 | {3'b000, p & ~(5'(1) << idx)});
    for (int k = 0; k < 20; k++) begin
      chk(busy == 1'b1, "R8 busy hold", k, 1);
      chk(mem_we == (k == 8 || k == 12), "R9 write timing", k, mem_we);
      if (k == 8) begin
        chk(mem_addr == sp0 - 16'd1, "R9 high addr", mem_addr, sp0 - 16'd1);
        chk(mem_wdata == pc0[15:8], "R9 high data", mem_wdata, pc0[15:8]);
      end
      if (k == 12) begin
        chk(mem_addr == sp0 - 16'd2, "R9 low addr", mem_addr, sp0 - 16'd2);
        chk(mem_wdata == pc0[7:0], "R9 low data", mem_wdata, pc0[7:0]);
      end
      chk(pc_load == (k == 19) && sp_load == (k == 19), "R8 load timing", k, 19);
      if (k == 19) begin
        chk(pc_out == 16'h0040 + 16'(8 * idx), "R7 vector", pc_out, 16'h0040 + 16'(8 * idx));
        chk(sp_out == sp0 - 16'd2, "R9 new sp", sp_out, sp0 - 16'd2);
      end
      step();
    end
    chk(busy == 1'b0, "R8 busy end", busy, 0);
  endtask

  initial begin
    #(8 * 120000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    step(); step();
    rst_n = 1'b1;
    step();

    // R11 reset state
    rd(A_FLAG, r); chk(r == 8'hE0, "R11 flag reset", r, 8'hE0);
    rd(A_EN, r);   chk(r == 8'hE0, "R11 enable reset", r, 8'hE0);
    chk(ime == 1'b0 && busy == 1'b0 && wake == 1'b0, "R11 ctrl reset",
        {ime, busy, wake}, 0);
    // R2 unmapped address
    rd(16'hFF0E, r); chk(r == 8'hFF, "R2 unmapped", r, 8'hFF);

    // R1 every request pattern with all enables off
    for (int p = 0; p < 32; p++) begin
      bus_wr(A_FLAG, 8'h00);
      req = 5'(p); step(); req = '0;
      rd(A_FLAG, r); chk(r == (8'hE0 | 8'(p)), "R1 latch masked", r, 8'hE0 | 8'(p));
      chk(wake == 1'b0, "R5 masked no wake", wake, 0);
    end
    // R1 sticky accumulation
    bus_wr(A_FLAG, 8'h00);
    req = 5'b00001; step(); req = 5'b00100; step(); req = '0; step();
    rd(A_FLAG, r); chk(r == 8'hE5, "R1 sticky", r, 8'hE5);

    // R4 request beats a clearing write
    bus_addr = A_FLAG; bus_wdata = 8'h00; bus_we = 1'b1; req = 5'b01000;
    step(); bus_we = 1'b0; req = '0;
    rd(A_FLAG, r); chk(r == 8'hE8, "R4 race", r, 8'hE8);

    // R3 / R5 full sweep, master enable off
    for (int e = 0; e < 32; e++) begin
      bus_wr(A_EN, 8'hA0 | 8'(e));
      rd(A_EN, r); chk(r == (8'hE0 | 8'(e)), "R3 enable store", r, 8'hE0 | 8'(e));
      for (int f = 0; f < 32; f++) begin
        bus_wr(A_FLAG, 8'h60 | 8'(f));
        rd(A_FLAG, r); chk(r == (8'hE0 | 8'(f)), "R3 flag store", r, 8'hE0 | 8'(f));
        chk(wake == ((e & f) != 0), "R5 wake", wake, (e & f) != 0);
        chk(busy == 1'b0, "R6 no dispatch with ime off", busy, 0);
      end
    end

    // R6 boundary without master enable
    bus_wr(A_EN, 8'h1F); bus_wr(A_FLAG, 8'h01);
    bound = 1'b1; step(); bound = 1'b0;
    chk(busy == 1'b0, "R6 ime off", busy, 0);
    // R6 master enable with nothing pending
    bus_wr(A_FLAG, 8'h00);
    ime_set = 1'b1; step(); ime_set = 1'b0;
    bound = 1'b1; step(); bound = 1'b0;
    chk(busy == 1'b0, "R6 none pending", busy, 0);
    // R10 clear strobe
    ime_clr = 1'b1; step(); ime_clr = 1'b0;
    chk(ime == 1'b0, "R10 ime clear", ime, 0);

    // R7 R8 R9 every non-empty pending set
    for (int p = 1; p < 32; p++)
      dispatch(5'(p), 16'h1200 + 16'(p * 37), 16'hD000 - 16'(p * 6), 1'b0);
    // R10 start overrides set in same cycle
    dispatch(5'b10100, 16'hA5C3, 16'hFFFE, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule